// File: doc/BRIEF.md
# Oversampling UART Receiver with Address Filtering

This block is the receive half of an asynchronous serial port. It watches a single serial input line, detects the falling edge that opens a start bit and times each bit from a 16x oversample tick. The tick is produced elsewhere. Each bit is decided by a two-of-three majority vote. The block assembles eight data bits and, in the long frame format, a ninth bit. The short format has 10 bits on the line (start, 8 data, stop). The long format has 11 bits (start, 8 data, ninth bit, stop).

A completed byte is handed to the receive buffer only when an acceptance rule holds. The rule looks at the receive enable, the sticky receive-done flag and an address-filter enable. With the filter enabled, only frames whose qualifying bit is 1 get through. The qualifying bit is the stop bit in the short format and the ninth bit in the long format. This lets a node on a multidrop line ignore data frames until it sees an address frame. Software reads the buffer and the received-ninth-bit register, then clears the done flag with a one-cycle strobe.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, rx_done, rx_data and rx_bit9 are all 0 and the receiver is idle.
- R2: A frame starts only on a 1-to-0 transition of the synchronized rx_in while rx_enable is 1. Dropping rx_enable during a frame abandons it, and no byte is delivered.
- R3: The oversample counter restarts at the start edge and counts os_tick pulses modulo 16. Each bit takes the majority of the line values sampled on counts 7, 8 and 9 of its 16-tick period, so a disturbance that flips only one of the three samples does not change the bit.
- R4: When the start bit votes to 1, the receiver drops the frame, loads nothing and returns to waiting for a falling edge.
- R5: Data bits arrive least significant first: the first data bit after the start bit lands in rx_data[0].
- R6: With long_frame=0 (10-bit frames), the accept decision is made at the middle of the stop bit, and an accepted frame stores the stop bit in rx_bit9.
- R7: With long_frame=1 (11-bit frames), the accept decision is made at the middle of the ninth bit, and an accepted frame stores the ninth bit in rx_bit9.
- R8: A frame is accepted only while rx_done is 0. A rejected frame leaves rx_data, rx_bit9 and rx_done unchanged.
- R9: With addr_filter=1, a frame is accepted only if its qualifying bit (stop bit in 10-bit mode, ninth bit in 11-bit mode) is 1. With addr_filter=0, that bit does not matter.
- R10: Acceptance sets rx_done, which then holds at 1 until a clr_done strobe or reset clears it.
- R11: Whether accepted or not, the receiver resumes looking for a falling edge after the middle of the stop bit. A frame that follows directly after the previous stop bit is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial receive line, idles high |
| rx_enable | input | 1 | Reception allowed while 1 |
| long_frame | input | 1 | 0: 10-bit frame, 1: 11-bit frame with ninth bit |
| addr_filter | input | 1 | 1: accept only frames whose qualifying bit is 1 |
| clr_done | input | 1 | One-cycle strobe that clears rx_done |
| rx_data | output | 8 | Receive buffer |
| rx_bit9 | output | 1 | Received ninth bit (stop bit in 10-bit mode) |
| rx_done | output | 1 | Sticky flag: a byte was accepted and is unread |

## Verification
The hardest situation to create from the ports is a line disturbance that flips exactly one of the three vote samples. The same goes for a start bit that is genuine at the falling edge but votes to 1. To reach both, the bench generates os_tick itself and places every start edge one clock after a tick, so the sample instants sit at known clock offsets within each bit. It then inverts the line over a window that covers only the middle sample, or ends a start bit just before the middle sample. A second hard case is a frame that begins right after the previous stop bit while the done flag was cleared mid-stop. The bench reaches it by pulsing the clear late in the stop bit and starting the next frame at once.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  // two-of-three majority
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // acceptance rule for a finished frame
  function automatic logic accept_ok(input logic en, input logic pend,
                                     input logic filt, input logic qual);
    return en & ~pend & (~filt | qual);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic os_tick,
  input  logic rx_s,
  output logic bit_valid,
  output logic bit_val
);
  localparam int CW     = $clog2(OSR);
  localparam int MID    = OSR / 2;
  localparam int SAMP_A = MID - 1;
  localparam int SAMP_B = MID;
  localparam int SAMP_C = MID + 1;

  logic [CW-1:0] cnt, cnt_nxt;
  logic          smp_a, smp_b;

  assign cnt_nxt = (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
    end else if (active && os_tick) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == CW'(SAMP_A)) smp_a <= rx_s;
      if (cnt_nxt == CW'(SAMP_B)) smp_b <= rx_s;
    end
  end

  // third sample is taken live; the bit is decided on that tick (R3)
  assign bit_valid = active & os_tick & (cnt_nxt == CW'(SAMP_C));
  assign bit_val   = vote3(smp_a, smp_b, rx_s);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              long_frame,
  input  logic              addr_filter,
  input  logic              rx_pend,
  input  logic              rx_s,
  input  logic              bit_valid,
  input  logic              bit_val,
  output logic              start_evt,
  output logic              running,
  output logic              accept_evt,
  output logic [DATA_W-1:0] data_byte,
  output logic              qual_bit
);
  localparam int IW         = $clog2(DATA_W + 3);
  localparam int DECIDE_IDX = DATA_W + 1;
  localparam int SHORT_LAST = DATA_W + 1;
  localparam int LONG_LAST  = DATA_W + 2;

  rx_state_e         state;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     last_idx;
  logic              mode_long;
  logic              prev_s;
  logic              fall;
  logic [DATA_W-1:0] shreg;
  logic              at_data;

  assign fall       = prev_s & ~rx_s;
  assign running    = (state == RX_RUN);
  assign start_evt  = (state == RX_IDLE) & rx_enable & fall;               // R2
  assign last_idx   = mode_long ? IW'(LONG_LAST) : IW'(SHORT_LAST);
  assign at_data    = (idx >= IW'(1)) && (idx <= IW'(DATA_W));
  assign accept_evt = running & bit_valid & (idx == IW'(DECIDE_IDX)) &
                      accept_ok(rx_enable, rx_pend, addr_filter, bit_val); // R6 R7 R8 R9
  assign data_byte  = shreg;
  assign qual_bit   = bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s <= 1'b1;
    else        prev_s <= rx_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      idx       <= '0;
      mode_long <= 1'b0;
      shreg     <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (start_evt) begin
            state     <= RX_RUN;
            idx       <= '0;
            mode_long <= long_frame;
          end
        end
        RX_RUN: begin
          if (!rx_enable) begin
            state <= RX_IDLE;                         // R2 abandon
          end else if (bit_valid) begin
            if (idx == '0 && bit_val) begin
              state <= RX_IDLE;                       // R4 false start
            end else if (idx == last_idx) begin
              state <= RX_IDLE;                       // R11 mid stop bit
            end else begin
              idx <= idx + 1'b1;
            end
            if (at_data) shreg <= {bit_val, shreg[DATA_W-1:1]};  // R5 LSB first
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              rx_enable,
  input  logic              long_frame,
  input  logic              addr_filter,
  input  logic              clr_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done
);
  logic              rx_s;
  logic              start_evt;
  logic              running;
  logic              bit_valid;
  logic              bit_val;
  logic              accept_evt;
  logic              qual_bit;
  logic [DATA_W-1:0] data_byte;

  uart_rx_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (rx_in),
    .q (rx_s)
  );

  uart_rx_sampler #(.OSR(OSR)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_evt),
    .active    (running),
    .os_tick   (os_tick),
    .rx_s      (rx_s),
    .bit_valid (bit_valid),
    .bit_val   (bit_val)
  );

  uart_rx_frame #(.DATA_W(DATA_W)) u_frm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .long_frame  (long_frame),
    .addr_filter (addr_filter),
    .rx_pend     (rx_done),
    .rx_s        (rx_s),
    .bit_valid   (bit_valid),
    .bit_val     (bit_val),
    .start_evt   (start_evt),
    .running     (running),
    .accept_evt  (accept_evt),
    .data_byte   (data_byte),
    .qual_bit    (qual_bit)
  );

  // output registers: R1 reset, R8 hold on reject, R10 sticky flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (accept_evt) begin
        rx_data <= data_byte;
        rx_bit9 <= qual_bit;
        rx_done <= 1'b1;
      end else if (clr_done) begin
        rx_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              addr_filter,
  input logic              clr_done,
  input logic              start_evt,
  input logic              running,
  input logic              bit_valid,
  input logic              accept_evt,
  input logic              qual_bit,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit9,
  input logic              rx_done
);
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> running); // R2
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !running); // R2
  AST_ACCEPT_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> bit_valid && running); // R7
  AST_ACCEPT_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !rx_done); // R8
  AST_HOLD_ON_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> $stable(rx_data) && $stable(rx_bit9)); // R8
  AST_FILTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && addr_filter |=> rx_bit9); // R9
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> rx_done); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !clr_done |=> rx_done); // R10
  AST_DONE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done && !accept_evt |=> !rx_done); // R10
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_enable   (rx_enable),
  .addr_filter (addr_filter),
  .clr_done    (clr_done),
  .start_evt   (start_evt),
  .running     (running),
  .bit_valid   (bit_valid),
  .accept_evt  (accept_evt),
  .qual_bit    (qual_bit),
  .rx_data     (rx_data),
  .rx_bit9     (rx_bit9),
  .rx_done     (rx_done)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
  localparam int TP  = 8;    // clocks per os_tick
  localparam int BIT = 128;  // clocks per bit = 16 * TP

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic       rx_enable = 1'b1;
  logic       long_frame = 1'b0;
  logic       addr_filter = 1'b0;
  logic       clr_done = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       rx_done;

  int nchecks = 0;
  int nfail = 0;
  int tphase = 0;
  bit finished = 0;

  logic [7:0] e_data = '0;
  logic       e_b9 = 1'b0;
  logic       e_done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uart_os_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .rx_enable(rx_enable), .long_frame(long_frame), .addr_filter(addr_filter),
    .clr_done(clr_done), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  function automatic logic exp_accept(input logic en, input logic pend,
                                      input logic filt, input logic q);
    if (!en)         return 1'b0;
    if (pend)        return 1'b0;
    if (filt && !q)  return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tclk(input logic lvl);
    @(negedge clk);
    rx_in   = lvl;
    os_tick = (tphase == 0);
    tphase  = (tphase + 1) % TP;
  endtask

  task automatic idle(input int n);
    repeat (n) tclk(1'b1);
  endtask

  task automatic pulse_clear();
    clr_done = 1'b1;
    tclk(1'b1);
    clr_done = 1'b0;
    e_done = 1'b0;
  endtask

  // glitch_bit: index of a bit whose middle sample is inverted (-1 none)
  // false_start: start bit ends before its middle sample
  // drop_bit: bit at which rx_enable falls (-1 none)
  // clr_late: pulse clr_done late in the stop bit
  task automatic send(input logic [7:0] d, input logic m11, input logic filt,
                      input logic nin, input logic stp, input int glitch_bit,
                      input bit false_start, input int drop_bit, input bit clr_late);
    logic fb [0:10];
    int   nb;
    logic lvl;
    logic en_all;
    logic q;
    long_frame  = m11;
    addr_filter = filt;
    fb[0] = 1'b0;
    for (int i = 0; i < 8; i++) fb[i+1] = d[i];
    if (m11) begin fb[9] = nin; fb[10] = stp; nb = 11; end
    else     begin fb[9] = stp; fb[10] = 1'b1; nb = 10; end
    if (false_start) nb = 1;
    en_all = rx_enable && (drop_bit < 0);
    q = m11 ? nin : stp;
    // align: the start edge is driven one clock after a tick
    do tclk(1'b1); while (!os_tick);
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < BIT; c++) begin
        lvl = fb[b];
        if (b == glitch_bit && c >= 58 && c <= 65) lvl = ~lvl;
        if (false_start && c >= 58) lvl = 1'b1;
        if (b == drop_bit && c == 0) rx_enable = 1'b0;
        if (clr_late && b == nb - 1 && c == 100) clr_done = 1'b1;
        if (clr_late && b == nb - 1 && c == 101) clr_done = 1'b0;
        tclk(lvl);
      end
    end
    if (!false_start && exp_accept(en_all, e_done, filt, q)) begin
      e_data = d;
      e_b9   = q;
      e_done = 1'b1;
    end
    if (clr_late) e_done = 1'b0;
    if (drop_bit >= 0) rx_enable = 1'b1;
  endtask

  task automatic check_out(input string tag);
    chk({tag, " data"}, 32'(rx_data), 32'(e_data));
    chk({tag, " bit9"}, 32'(rx_bit9), 32'(e_b9));
    chk({tag, " done"}, 32'(rx_done), 32'(e_done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(5);
    check_out("R1 reset");
    rst_n = 1'b1;
    idle(20);
    check_out("R1 after release");

    // R5 R6: 10-bit, stop=1 stored in bit9
    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, -1, 0);
    idle(40);
    chk("R5 data lsb first", 32'(rx_data), 32'h A5);
    check_out("R6 10-bit accept");

    // R8: pending byte blocks next frame
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R8 pending reject");

    // R10: clear strobe
    chk("R10 sticky", 32'(rx_done), 32'd1);
    pulse_clear();
    idle(3);
    check_out("R10 cleared");

    // R9: 11-bit ninth=0 with filter -> rejected
    send(8'h77, 1'b1, 1'b1, 1'b0, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R9 filter reject");

    // R7 R9: 11-bit ninth=1 with filter -> accepted
    send(8'h81, 1'b1, 1'b1, 1'b1, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R7 R9 filter accept");
    pulse_clear();

    // R7: ninth=0, no filter
    send(8'h5E, 1'b1, 1'b0, 1'b0, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R7 ninth zero");
    pulse_clear();

    // R9: 10-bit filter with stop=0 rejected, stop=1 accepted
    send(8'h12, 1'b0, 1'b1, 1'b0, 1'b0, -1, 0, -1, 0);
    idle(40);
    check_out("R9 10-bit stop0 reject");
    send(8'h34, 1'b0, 1'b1, 1'b0, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R9 10-bit stop1 accept");
    pulse_clear();

    // R3: one flipped sample in several bits
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3, 0, -1, 0);
    idle(40);
    check_out("R3 glitch data bit");
    pulse_clear();
    send(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 0, 0, -1, 0);
    idle(40);
    check_out("R3 glitch start bit");
    pulse_clear();

    // R4: false start
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1, -1, 0);
    idle(40);
    check_out("R4 false start");
    // R4 R11: receiver still works after a false start
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R4 recover");
    pulse_clear();

    // R2: disabled whole frame, then dropped mid-frame
    rx_enable = 1'b0;
    send(8'h99, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, -1, 0);
    rx_enable = 1'b1;
    idle(40);
    check_out("R2 disabled");
    send(8'h66, 1'b1, 1'b0, 1'b1, 1'b1, -1, 0, 4, 0);
    idle(40);
    check_out("R2 dropped mid frame");

    // R11: back-to-back frames, clear late in first stop bit
    send(8'h4B, 1'b0, 1'b0, 1'b0, 1'b1, -1, 0, -1, 1);
    chk("R11 first cleared", 32'(rx_done), 32'd0);
    send(8'hB4, 1'b1, 1'b0, 1'b1, 1'b1, -1, 0, -1, 0);
    idle(40);
    check_out("R11 back to back");
    pulse_clear();

    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic m11, filt, nin, stp;
      int gb;
      d    = 8'($urandom);
      m11  = 1'($urandom);
      filt = ($urandom_range(0, 2) == 0);
      nin  = 1'($urandom);
      stp  = m11 ? 1'b1 : ($urandom_range(0, 3) != 0);
      gb   = $urandom_range(0, 12);
      if (gb > 10) gb = -1;
      if ($urandom_range(0, 1) == 1) pulse_clear();
      rx_enable = ($urandom_range(0, 7) != 0);
      send(d, m11, filt, nin, stp, gb, 0, -1, 0);
      rx_enable = 1'b1;
      idle(40);
      check_out("R3/R5/R8/R9 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule